// File: doc/BRIEF.md
# Interrupt Controller Host Command Decoder

This block is the byte-wide register front end of one programmable interrupt controller instance. A host writes and reads single bytes through a two-location main port, selected by one address bit, and through a separate trigger-mode port. The decoder runs the multi-word initialization sequence, and it holds the mask, the vector base and the mode flags. It turns operation commands into single-cycle control pulses for the request core beside it, and it selects the byte returned on reads. Priority resolution is not part of this block. The core supplies its request and in-service registers and its current poll candidate.

Writes to main location 0 are sorted by data bits 4 and 3. Bit 4 set starts initialization. Bit 4 clear with bit 3 set is a read/poll command. Both clear is an operation command whose opcode is in bits 7:5. The sequencer has four named states. `ST_IDLE` is normal operation. `ST_WAIT_BASE` waits for the vector base word. `ST_WAIT_CASC` waits for the cascade word. `ST_WAIT_MODE` waits for the optional mode word. The transitions are: start word (any state) to `ST_WAIT_BASE`; location-1 write in `ST_WAIT_BASE` to `ST_WAIT_CASC`; location-1 write in `ST_WAIT_CASC` to `ST_WAIT_MODE` when a mode word was announced, otherwise to `ST_IDLE`; location-1 write in `ST_WAIT_MODE` to `ST_IDLE`. A location-1 write in `ST_IDLE` loads the mask and the state stays `ST_IDLE`.

Top module: `pic_cmd_decoder`

## Requirements
- R1: After reset, the state is `ST_IDLE`, every control output and pulse is 0, and a main-port read at location 0 returns `core_irr`.
- R2: A main write at location 0 with bit 4 = 1 clears the mask, vector base, nested and auto-EOI modes, rotate-on-auto-EOI, special mask, read select and any pending poll. It records data bit 0 as "mode word expected", enters `ST_WAIT_BASE`, and raises `init_clr_p` for the single cycle after the write.
- R3: In `ST_WAIT_BASE`, a location-1 write stores `wdata & 8'hF8` into `ctl_vbase`.
- R4: In `ST_WAIT_CASC`, a location-1 write changes no control output. It leads to `ST_WAIT_MODE` if bit 0 of the start word was 1, otherwise to `ST_IDLE`.
- R5: In `ST_WAIT_MODE`, a location-1 write sets `ctl_nested` from data bit 4 and `ctl_auto_eoi` from data bit 1, then returns to `ST_IDLE`.
- R6: A location-1 write loads `ctl_mask` only in `ST_IDLE`. During the other states it leaves the mask unchanged.
- R7: A location-0 write with bit 4 = 0 and bit 3 = 1 sets the poll-pending flag when bit 2 = 1. It loads the read select from bit 0 only when bit 1 = 1. It loads `ctl_special_mask` from bit 5 only when bit 6 = 1.
- R8: A location-0 write with bits 4 and 3 both 0 is an operation command with opcode bits 7:5. Opcode 0 clears `ctl_rot_aeoi`, opcode 4 sets it, and opcode 2 changes no output and raises no pulse.
- R9: Opcodes 1, 5, 3 and 7 raise `eoi_p` for the cycle after the write. `eoi_specific` is 1 for opcodes 3 and 7, and then `eoi_id = wdata[2:0]`. `eoi_rotate` is 1 for opcodes 5 and 7.
- R10: Opcode 6 raises `prio_set_p` for the cycle after the write, with `prio_base = (wdata[2:0] + 1) mod 8`.
- R11: A read answers in the same cycle. On the main port, location 0 returns `core_isr` when the read select is 1 and `core_irr` otherwise, and location 1 returns `ctl_mask`. On the trigger port, the read returns `ctl_trig`.
- R12: With a poll pending, the next main-port read returns the candidate number in bits 2:0 with zero upper bits, and raises `poll_clr_p` with `poll_clr_id` in the same cycle. If no candidate is valid, the read returns 8'h07 and raises no pulse. Either way the poll flag is cleared after that read.
- R13: A trigger-port write stores `wdata` ANDed with 8'hF8 when `IS_SLAVE` = 0, or with 8'hDE when `IS_SLAVE` = 1. It does not affect the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| trig_sel | input | 1 | 1 selects the trigger-mode port, 0 the main port |
| addr | input | 1 | Main-port location (0 or 1) |
| wdata | input | 8 | Write data byte |
| core_irr | input | 8 | Request register from the core |
| core_isr | input | 8 | In-service register from the core |
| poll_valid | input | 1 | Core has a poll candidate |
| poll_id | input | 3 | Core's poll candidate number |
| rdata | output | 8 | Read data, valid while rd_en is high |
| ctl_mask | output | 8 | Interrupt mask |
| ctl_vbase | output | 8 | Vector base (low 3 bits zero) |
| ctl_trig | output | 8 | Trigger-mode register (1 = level) |
| ctl_nested | output | 1 | Special fully nested mode |
| ctl_auto_eoi | output | 1 | Auto-EOI mode |
| ctl_rot_aeoi | output | 1 | Rotate on auto-EOI |
| ctl_special_mask | output | 1 | Special mask mode |
| init_clr_p | output | 1 | Pulse: core clears request, in-service and rotation |
| eoi_p | output | 1 | Pulse: end of interrupt |
| eoi_specific | output | 1 | EOI names an input explicitly |
| eoi_rotate | output | 1 | EOI also rotates priority |
| eoi_id | output | 3 | Input named by a specific EOI |
| prio_set_p | output | 1 | Pulse: load rotation base |
| prio_base | output | 3 | New rotation base |
| poll_clr_p | output | 1 | Pulse: clear request and in-service of poll_clr_id |
| poll_clr_id | output | 3 | Input taken by the poll read |

## Verification
The start word is tried once with the mode word announced and once without. In each case the bench watches which location-1 write first lands in the mask, which tells a four-word sequence from a three-word one. It also checks that state set before the start word has been cleared. Each opcode is written with data whose low bits differ from the opcode, so a wrong field slice or a missing rotation increment shows up as a wrong `eoi_id` or `prio_base`. Read/poll commands are sent with their enable bits both set and clear, to tell conditional loads from unconditional ones. A poll is read once with a candidate and once without, followed by a plain read, which shows whether the flag clears.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_BASE = 2'd1,
        ST_WAIT_CASC = 2'd2,
        ST_WAIT_MODE = 2'd3
    } seq_state_t;

    typedef enum logic [2:0] {
        OP_ROT_AEOI_OFF = 3'd0,
        OP_EOI          = 3'd1,
        OP_NOP          = 3'd2,
        OP_EOI_SPEC     = 3'd3,
        OP_ROT_AEOI_ON  = 3'd4,
        OP_EOI_ROT      = 3'd5,
        OP_SET_PRIO     = 3'd6,
        OP_EOI_SPEC_ROT = 3'd7
    } op_code_t;
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_cmd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ID_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_wr,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              init_start,
    output logic [DATA_W-1:0] ctl_mask,
    output logic [DATA_W-1:0] ctl_vbase,
    output logic              ctl_nested,
    output logic              ctl_auto_eoi,
    output logic              init_clr_p
);
    localparam logic [DATA_W-1:0] BASE_KEEP = ~((DATA_W)'((1 << ID_W) - 1));

    seq_state_t state, nxt;
    logic       want_mode;
    logic       data_wr;

    assign init_start = main_wr && !addr && wdata[4];
    assign data_wr    = main_wr && addr;

    // next-state logic
    always_comb begin
        nxt = state;
        if (init_start) begin
            nxt = ST_WAIT_BASE;
        end else if (data_wr) begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_WAIT_BASE: nxt = ST_WAIT_CASC;
                ST_WAIT_CASC: nxt = want_mode ? ST_WAIT_MODE : ST_IDLE;
                ST_WAIT_MODE: nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_mask     <= '0;
            ctl_vbase    <= '0;
            ctl_nested   <= 1'b0;
            ctl_auto_eoi <= 1'b0;
            want_mode    <= 1'b0;
            init_clr_p   <= 1'b0;
        end else begin
            init_clr_p <= init_start;
            if (init_start) begin
                ctl_mask     <= '0;
                ctl_vbase    <= '0;
                ctl_nested   <= 1'b0;
                ctl_auto_eoi <= 1'b0;
                want_mode    <= wdata[0];
            end else if (data_wr) begin
                unique case (state)
                    ST_IDLE:      ctl_mask <= wdata;
                    ST_WAIT_BASE: ctl_vbase <= wdata & BASE_KEEP;
                    ST_WAIT_CASC: ;
                    ST_WAIT_MODE: begin
                        ctl_nested   <= wdata[4];
                        ctl_auto_eoi <= wdata[1];
                    end
                endcase
            end
        end
    end

    assert_start_enters_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |=> (state == ST_WAIT_BASE));

    assert_base_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !init_start && state == ST_WAIT_BASE) |=> (ctl_vbase[ID_W-1:0] == '0));

    assert_mask_held_in_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !init_start && state != ST_IDLE) |=> $stable(ctl_mask));
endmodule

// File: rtl/pic_op_decode.sv
module pic_op_decode
    import pic_cmd_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ID_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_wr,
    input  logic              main_rd,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              init_start,
    output logic              ctl_rot_aeoi,
    output logic              ctl_special_mask,
    output logic              rd_isr,
    output logic              poll_pending,
    output logic              eoi_p,
    output logic              eoi_specific,
    output logic              eoi_rotate,
    output logic [ID_W-1:0]   eoi_id,
    output logic              prio_set_p,
    output logic [ID_W-1:0]   prio_base
);
    logic     is_rdcmd, is_opcmd;
    op_code_t op;

    assign is_rdcmd = main_wr && !addr && !wdata[4] && wdata[3];
    assign is_opcmd = main_wr && !addr && !wdata[4] && !wdata[3];
    assign op       = op_code_t'(wdata[7:5]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_rot_aeoi     <= 1'b0;
            ctl_special_mask <= 1'b0;
            rd_isr           <= 1'b0;
            poll_pending     <= 1'b0;
            eoi_p            <= 1'b0;
            eoi_specific     <= 1'b0;
            eoi_rotate       <= 1'b0;
            eoi_id           <= '0;
            prio_set_p       <= 1'b0;
            prio_base        <= '0;
        end else begin
            eoi_p      <= 1'b0;
            prio_set_p <= 1'b0;
            if (main_rd) poll_pending <= 1'b0;
            if (init_start) begin
                ctl_rot_aeoi     <= 1'b0;
                ctl_special_mask <= 1'b0;
                rd_isr           <= 1'b0;
                poll_pending     <= 1'b0;
            end else if (is_rdcmd) begin
                if (wdata[2]) poll_pending     <= 1'b1;
                if (wdata[1]) rd_isr           <= wdata[0];
                if (wdata[6]) ctl_special_mask <= wdata[5];
            end else if (is_opcmd) begin
                unique case (op)
                    OP_ROT_AEOI_OFF: ctl_rot_aeoi <= 1'b0;
                    OP_ROT_AEOI_ON:  ctl_rot_aeoi <= 1'b1;
                    OP_NOP:          ;
                    OP_EOI, OP_EOI_ROT, OP_EOI_SPEC, OP_EOI_SPEC_ROT: begin
                        eoi_p        <= 1'b1;
                        eoi_specific <= wdata[5] && wdata[6];
                        eoi_rotate   <= wdata[7];
                        eoi_id       <= wdata[ID_W-1:0];
                    end
                    OP_SET_PRIO: begin
                        prio_set_p <= 1'b1;
                        prio_base  <= wdata[ID_W-1:0] + 1'b1;
                    end
                endcase
            end
        end
    end

    assert_eoi_from_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_p |-> $past(main_wr));

    assert_prio_from_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        prio_set_p |-> $past(main_wr));

    assert_one_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eoi_p, prio_set_p}));

    assert_poll_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (main_rd && !main_wr) |=> !poll_pending);
endmodule

// File: rtl/pic_readback.sv
module pic_readback #(
    parameter int DATA_W = 8,
    parameter int ID_W   = 3
) (
    input  logic              rd_en,
    input  logic              trig_sel,
    input  logic              addr,
    input  logic              rd_isr,
    input  logic              poll_pending,
    input  logic [DATA_W-1:0] core_irr,
    input  logic [DATA_W-1:0] core_isr,
    input  logic [DATA_W-1:0] ctl_mask,
    input  logic [DATA_W-1:0] ctl_trig,
    input  logic              poll_valid,
    input  logic [ID_W-1:0]   poll_id,
    output logic [DATA_W-1:0] rdata,
    output logic              poll_clr_p,
    output logic [ID_W-1:0]   poll_clr_id
);
    localparam logic [DATA_W-1:0] NO_CAND = DATA_W'((1 << ID_W) - 1);

    always_comb begin
        rdata       = '0;
        poll_clr_p  = 1'b0;
        poll_clr_id = poll_id;
        if (rd_en) begin
            if (trig_sel) begin
                rdata = ctl_trig;
            end else if (poll_pending) begin
                poll_clr_p = poll_valid;
                rdata      = poll_valid ? DATA_W'(poll_id) : NO_CAND;
            end else if (addr) begin
                rdata = ctl_mask;
            end else begin
                rdata = rd_isr ? core_isr : core_irr;
            end
        end
    end
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder #(
    parameter int          DATA_W     = 8,
    parameter bit          IS_SLAVE   = 1'b0,
    parameter logic [7:0]  MSTR_TMASK = 8'hF8,
    parameter logic [7:0]  SLV_TMASK  = 8'hDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              trig_sel,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] core_irr,
    input  logic [DATA_W-1:0] core_isr,
    input  logic              poll_valid,
    input  logic [2:0]        poll_id,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ctl_mask,
    output logic [DATA_W-1:0] ctl_vbase,
    output logic [DATA_W-1:0] ctl_trig,
    output logic              ctl_nested,
    output logic              ctl_auto_eoi,
    output logic              ctl_rot_aeoi,
    output logic              ctl_special_mask,
    output logic              init_clr_p,
    output logic              eoi_p,
    output logic              eoi_specific,
    output logic              eoi_rotate,
    output logic [2:0]        eoi_id,
    output logic              prio_set_p,
    output logic [2:0]        prio_base,
    output logic              poll_clr_p,
    output logic [2:0]        poll_clr_id
);
    localparam int                ID_W      = $clog2(DATA_W);
    localparam logic [DATA_W-1:0] TRIG_KEEP = IS_SLAVE ? DATA_W'(SLV_TMASK) : DATA_W'(MSTR_TMASK);

    logic main_wr, main_rd, trig_wr;
    logic init_start, rd_isr, poll_pending;

    assign main_wr = wr_en && !trig_sel;
    assign main_rd = rd_en && !trig_sel;
    assign trig_wr = wr_en && trig_sel;

    always_ff @(posedge clk) begin
        if (!rst_n)       ctl_trig <= '0;
        else if (trig_wr) ctl_trig <= wdata & TRIG_KEEP;
    end

    pic_init_seq #(.DATA_W(DATA_W), .ID_W(ID_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .main_wr(main_wr), .addr(addr), .wdata(wdata),
        .init_start(init_start), .ctl_mask(ctl_mask), .ctl_vbase(ctl_vbase),
        .ctl_nested(ctl_nested), .ctl_auto_eoi(ctl_auto_eoi), .init_clr_p(init_clr_p)
    );

    pic_op_decode #(.DATA_W(DATA_W), .ID_W(ID_W)) u_op (
        .clk(clk), .rst_n(rst_n), .main_wr(main_wr), .main_rd(main_rd), .addr(addr),
        .wdata(wdata), .init_start(init_start), .ctl_rot_aeoi(ctl_rot_aeoi),
        .ctl_special_mask(ctl_special_mask), .rd_isr(rd_isr), .poll_pending(poll_pending),
        .eoi_p(eoi_p), .eoi_specific(eoi_specific), .eoi_rotate(eoi_rotate),
        .eoi_id(eoi_id), .prio_set_p(prio_set_p), .prio_base(prio_base)
    );

    pic_readback #(.DATA_W(DATA_W), .ID_W(ID_W)) u_rb (
        .rd_en(rd_en), .trig_sel(trig_sel), .addr(addr), .rd_isr(rd_isr),
        .poll_pending(poll_pending), .core_irr(core_irr), .core_isr(core_isr),
        .ctl_mask(ctl_mask), .ctl_trig(ctl_trig), .poll_valid(poll_valid),
        .poll_id(poll_id), .rdata(rdata), .poll_clr_p(poll_clr_p), .poll_clr_id(poll_clr_id)
    );

    assert_trig_masked_R13: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr |=> ((ctl_trig & ~TRIG_KEEP) == '0));

    assert_trig_spares_mask_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_wr && !main_wr) |=> $stable(ctl_mask));

    assert_pulses_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({init_clr_p, eoi_p, prio_set_p}));
endmodule

// File: tb/pic_cmd_decoder_tb.sv
module pic_cmd_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, trig_sel = 1'b0, addr = 1'b0;
    logic [7:0] wdata = '0, core_irr = 8'h5A, core_isr = 8'hA5;
    logic       poll_valid = 1'b0;
    logic [2:0] poll_id = '0;
    logic [7:0] rdata, ctl_mask, ctl_vbase, ctl_trig;
    logic       ctl_nested, ctl_auto_eoi, ctl_rot_aeoi, ctl_special_mask;
    logic       init_clr_p, eoi_p, eoi_specific, eoi_rotate, prio_set_p, poll_clr_p;
    logic [2:0] eoi_id, prio_base, poll_clr_id;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    pic_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .trig_sel(trig_sel),
        .addr(addr), .wdata(wdata), .core_irr(core_irr), .core_isr(core_isr),
        .poll_valid(poll_valid), .poll_id(poll_id), .rdata(rdata), .ctl_mask(ctl_mask),
        .ctl_vbase(ctl_vbase), .ctl_trig(ctl_trig), .ctl_nested(ctl_nested),
        .ctl_auto_eoi(ctl_auto_eoi), .ctl_rot_aeoi(ctl_rot_aeoi),
        .ctl_special_mask(ctl_special_mask), .init_clr_p(init_clr_p), .eoi_p(eoi_p),
        .eoi_specific(eoi_specific), .eoi_rotate(eoi_rotate), .eoi_id(eoi_id),
        .prio_set_p(prio_set_p), .prio_base(prio_base), .poll_clr_p(poll_clr_p),
        .poll_clr_id(poll_clr_id)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // write: sampled at the posedge between two falling edges; returns in the cycle after
    task automatic wr(input logic t, input logic a, input logic [7:0] d);
        @(negedge clk);
        trig_sel = t; addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic t, input logic a, output logic [7:0] d, output logic clr,
                      output logic [2:0] cid);
        @(negedge clk);
        trig_sel = t; addr = a; rd_en = 1'b1;
        #1;
        d = rdata; clr = poll_clr_p; cid = poll_clr_id;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d; logic c; logic [2:0] id;
        chk("R1 mask", ctl_mask, 8'h00);
        chk("R1 vbase", ctl_vbase, 8'h00);
        chk("R1 flags", {2'b0, ctl_nested, ctl_auto_eoi, ctl_rot_aeoi, ctl_special_mask,
                         init_clr_p, eoi_p}, 8'h00);
        chk("R1 prio pulse", {7'b0, prio_set_p}, 8'h00);
        rd(1'b0, 1'b0, d, c, id);
        chk("R1 R11 read irr", d, 8'h5A);
    endtask

    task automatic t_init_full;
        wr(1'b0, 1'b0, 8'h11);
        chk("R2 init pulse", {7'b0, init_clr_p}, 8'h01);
        @(negedge clk);
        chk("R2 pulse single", {7'b0, init_clr_p}, 8'h00);
        wr(1'b0, 1'b1, 8'h47);
        chk("R3 vbase", ctl_vbase, 8'h40);
        chk("R6 mask held", ctl_mask, 8'h00);
        wr(1'b0, 1'b1, 8'h04);
        chk("R4 cascade ignored", {ctl_mask[3:0], 2'b0, ctl_nested, ctl_auto_eoi}, 8'h00);
        wr(1'b0, 1'b1, 8'h12);
        chk("R5 modes", {6'b0, ctl_nested, ctl_auto_eoi}, 8'h03);
        chk("R6 mask held mode", ctl_mask, 8'h00);
        wr(1'b0, 1'b1, 8'h3C);
        chk("R6 mask idle", ctl_mask, 8'h3C);
    endtask

    task automatic t_readcmds;
        logic [7:0] d; logic c; logic [2:0] id;
        wr(1'b0, 1'b0, 8'h0B);
        rd(1'b0, 1'b0, d, c, id);
        chk("R7 R11 read isr", d, 8'hA5);
        wr(1'b0, 1'b0, 8'h09);
        rd(1'b0, 1'b0, d, c, id);
        chk("R7 select not loaded", d, 8'hA5);
        wr(1'b0, 1'b0, 8'h0A);
        rd(1'b0, 1'b0, d, c, id);
        chk("R7 select cleared", d, 8'h5A);
        rd(1'b0, 1'b1, d, c, id);
        chk("R11 read mask", d, 8'h3C);
        wr(1'b0, 1'b0, 8'h68);
        chk("R7 smm set", {7'b0, ctl_special_mask}, 8'h01);
        wr(1'b0, 1'b0, 8'h08);
        chk("R7 smm kept", {7'b0, ctl_special_mask}, 8'h01);
        wr(1'b0, 1'b0, 8'h48);
        chk("R7 smm cleared", {7'b0, ctl_special_mask}, 8'h00);
    endtask

    task automatic t_init_short;
        logic [7:0] d; logic c; logic [2:0] id;
        wr(1'b0, 1'b1, 8'hFF);
        wr(1'b0, 1'b0, 8'h0B);
        wr(1'b0, 1'b0, 8'h68);
        wr(1'b0, 1'b0, 8'h80);
        wr(1'b0, 1'b0, 8'h0C);
        wr(1'b0, 1'b0, 8'h10);
        chk("R2 clears mask", ctl_mask, 8'h00);
        chk("R2 clears vbase", ctl_vbase, 8'h00);
        chk("R2 clears modes", {4'b0, ctl_nested, ctl_auto_eoi, ctl_rot_aeoi, ctl_special_mask},
            8'h00);
        poll_valid = 1'b1; poll_id = 3'd6;
        rd(1'b0, 1'b0, d, c, id);
        chk("R2 clears select and poll", d, 8'h5A);
        chk("R2 no poll pulse", {7'b0, c}, 8'h00);
        poll_valid = 1'b0;
        wr(1'b0, 1'b1, 8'h08);
        chk("R3 vbase short", ctl_vbase, 8'h08);
        wr(1'b0, 1'b1, 8'hAA);
        chk("R4 no mask load", ctl_mask, 8'h00);
        wr(1'b0, 1'b1, 8'h81);
        chk("R4 mode word skipped", ctl_mask, 8'h81);
        chk("R4 modes untouched", {6'b0, ctl_nested, ctl_auto_eoi}, 8'h00);
    endtask

    task automatic t_rot;
        wr(1'b0, 1'b0, 8'h80);
        chk("R8 rot set", {7'b0, ctl_rot_aeoi}, 8'h01);
        wr(1'b0, 1'b0, 8'h47);
        chk("R8 nop state", {ctl_mask[7:1], ctl_rot_aeoi}, 8'h81);
        chk("R8 nop pulses", {5'b0, init_clr_p, eoi_p, prio_set_p}, 8'h00);
        wr(1'b0, 1'b0, 8'h00);
        chk("R8 rot clear", {7'b0, ctl_rot_aeoi}, 8'h00);
    endtask

    task automatic t_eoi;
        wr(1'b0, 1'b0, 8'h20);
        chk("R9 nonspec", {5'b0, eoi_p, eoi_specific, eoi_rotate}, 8'h04);
        @(negedge clk);
        chk("R9 pulse single", {7'b0, eoi_p}, 8'h00);
        wr(1'b0, 1'b0, 8'hA0);
        chk("R9 nonspec rot", {5'b0, eoi_p, eoi_specific, eoi_rotate}, 8'h05);
        wr(1'b0, 1'b0, 8'h65);
        chk("R9 specific", {2'b0, eoi_p, eoi_specific, eoi_rotate, eoi_id}, 8'h35);
        wr(1'b0, 1'b0, 8'hE2);
        chk("R9 specific rot", {2'b0, eoi_p, eoi_specific, eoi_rotate, eoi_id}, 8'h3A);
    endtask

    task automatic t_prio;
        wr(1'b0, 1'b0, 8'hC7);
        chk("R10 wrap", {4'b0, prio_set_p, prio_base}, 8'h08);
        chk("R10 no eoi", {7'b0, eoi_p}, 8'h00);
        wr(1'b0, 1'b0, 8'hC3);
        chk("R10 base", {4'b0, prio_set_p, prio_base}, 8'h0C);
    endtask

    task automatic t_poll;
        logic [7:0] d; logic c; logic [2:0] id;
        wr(1'b0, 1'b0, 8'h0C);
        poll_valid = 1'b1; poll_id = 3'd3;
        rd(1'b0, 1'b0, d, c, id);
        chk("R12 poll data", d, 8'h03);
        chk("R12 poll pulse", {4'b0, c, id}, 8'h0B);
        rd(1'b0, 1'b0, d, c, id);
        chk("R12 flag cleared", d, 8'h5A);
        chk("R12 no second pulse", {7'b0, c}, 8'h00);
        wr(1'b0, 1'b0, 8'h0C);
        poll_valid = 1'b0;
        rd(1'b0, 1'b1, d, c, id);
        chk("R12 no candidate", d, 8'h07);
        chk("R12 no candidate pulse", {7'b0, c}, 8'h00);
        rd(1'b0, 1'b1, d, c, id);
        chk("R12 flag cleared empty", d, 8'h81);
    endtask

    task automatic t_trig;
        logic [7:0] d; logic c; logic [2:0] id;
        wr(1'b1, 1'b1, 8'hFF);
        chk("R13 trig masked", ctl_trig, 8'hF8);
        chk("R13 mask spared", ctl_mask, 8'h81);
        rd(1'b1, 1'b0, d, c, id);
        chk("R11 R13 trig read", d, 8'hF8);
        wr(1'b1, 1'b0, 8'h07);
        chk("R13 low bits dropped", ctl_trig, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_init_full;
        t_readcmds;
        t_init_short;
        t_rot;
        t_eoi;
        t_prio;
        t_poll;
        t_trig;
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule